// File: doc/BRIEF.md
# Hot-Plug Slot Power-Up Sequencer

One instance of this block controls one downstream hot-plug slot. When the reset input is released, it decides once whether the slot may be powered. It bases that decision on the slot's configuration bits and, when a retention-latch sensor is fitted, on the latch state at that moment. A slot that is cleared for power gets its power-enable and power-indicator outputs driven low, together, after a fixed number of reference-clock cycles. The delay is longer when a configuration EEPROM was detected.

The configuration inputs are strap-like levels. They are captured together with the latch sample on the first clock edge after reset exit, and later changes are ignored until the next reset. The latch input is asynchronous and is resynchronised before it is used. The attention indicator is never driven by this block and stays high. The two delays are parameters in reference-clock cycles. Their defaults assume a 100 MHz clock: about 6.1 ms without an EEPROM and 18.7 ms with one.

Top module: `hp_slot_seq`

## Requirements
- R1: While rst_ni is low, pwr_en_no, pwr_led_no and attn_led_no are 1 and pwr_ctrl_o is 1 (slot off). This applies without waiting for a clock edge.
- R2: attn_led_no is 1 in every cycle.
- R3: If cfg_mrl_present_i is 1 and mrl_ni is 0 (latch closed) at reset exit, pwr_ctrl_o reads 0 from the first clock edge after reset exit.
- R4: If cfg_mrl_present_i is 1 and mrl_ni is 1 (latch open) at reset exit, pwr_ctrl_o takes cfg_pwr_ctrl_i. While pwr_ctrl_o is 1, the slot is never powered.
- R5: If cfg_mrl_present_i is 0, pwr_ctrl_o takes cfg_pwr_ctrl_i, and mrl_ni has no effect.
- R6: Power-up happens only when cfg_ctrl_present_i is 1 and the resolved power-control value is 0. Otherwise pwr_en_no and pwr_led_no stay 1.
- R7: With eeprom_present_i at 0, a slot cleared for power has pwr_en_no and pwr_led_no go low together right after rising edge number DLY_NOEE, counted from the first edge after reset exit as edge 1.
- R8: With eeprom_present_i at 1, the same happens after edge number DLY_EE.
- R9: Changes to mrl_ni, eeprom_present_i or any configuration bit after the first edge after reset exit do not alter pwr_ctrl_o or the power outputs. Once powered, the slot stays powered until reset.
- R10: Asserting rst_ni again returns every output to its inactive state and clears the delay count. The next reset exit restarts the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release starts the sequence |
| mrl_ni | input | 1 | Retention-latch sensor, low when closed, asynchronous |
| eeprom_present_i | input | 1 | Configuration EEPROM detected |
| cfg_ctrl_present_i | input | 1 | Slot has a power controller |
| cfg_mrl_present_i | input | 1 | Slot has a latch sensor |
| cfg_pwr_ctrl_i | input | 1 | Loaded power-control value, 1 = off |
| pwr_en_no | output | 1 | Slot power enable, active low |
| pwr_led_no | output | 1 | Power indicator, active low |
| attn_led_no | output | 1 | Attention indicator, active low |
| pwr_ctrl_o | output | 1 | Resolved power-control value, 1 = off |

## Verification
The resolved power-control value is due after the first rising edge following reset exit. The power outputs fall after exactly DLY_NOEE or DLY_EE edges, and a reset assertion acts at once, with no edge. The bench releases reset on a falling edge and numbers the following rising edges from 1. It samples on each falling edge after rising edge k, so every check compares against a value that has already settled: power off for k < D and on for k ≥ D. The reset-state check is taken one nanosecond after reset is asserted, between clock edges.

// File: rtl/hp_seq_pkg.sv
package hp_seq_pkg;
  typedef struct packed {
    logic ctrl_present;
    logic mrl_present;
    logic pwr_ctrl;
    logic eeprom;
  } slot_cfg_t;

  localparam slot_cfg_t CFG_RST = '{ctrl_present: 1'b1, mrl_present: 1'b1,
                                     pwr_ctrl: 1'b1, eeprom: 1'b0};
endpackage

// File: rtl/hp_mrl_sync.sv
module hp_mrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic mrl_ni,
  output logic mrl_sync_no
);
  logic [STAGES-1:0] sync_q;

  // no reset: the latch level must be valid at the moment reset exits
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) sync_q <= mrl_ni;
    end else begin : g_chain
      always_ff @(posedge clk_i) sync_q <= {sync_q[STAGES-2:0], mrl_ni};
    end
  endgenerate

  assign mrl_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/hp_pwr_decide.sv
module hp_pwr_decide
  import hp_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mrl_sync_ni,
  input  slot_cfg_t cfg_i,
  output logic      sampled_o,
  output slot_cfg_t cfg_o
);
  logic      sampled_q;
  slot_cfg_t cfg_q;
  logic      pwr_ctrl_d;

  // latch closed with sensor fitted clears power-control
  assign pwr_ctrl_d = cfg_i.pwr_ctrl & ~(cfg_i.mrl_present & ~mrl_sync_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sampled_q <= 1'b0;
      cfg_q     <= CFG_RST;
    end else if (!sampled_q) begin
      sampled_q          <= 1'b1;
      cfg_q.ctrl_present <= cfg_i.ctrl_present;
      cfg_q.mrl_present  <= cfg_i.mrl_present;
      cfg_q.eeprom       <= cfg_i.eeprom;
      cfg_q.pwr_ctrl     <= pwr_ctrl_d;
    end
  end

  assign sampled_o = sampled_q;
  assign cfg_o     = cfg_q;

  AST_SAMPLE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampled_q |=> $stable(cfg_q)); // R9
  AST_MRL_CLOSED_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sampled_q && cfg_i.mrl_present && !mrl_sync_ni) |=> !cfg_q.pwr_ctrl); // R3
  AST_NO_SENSOR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sampled_q && !cfg_i.mrl_present) |=> (cfg_q.pwr_ctrl == $past(cfg_i.pwr_ctrl))); // R5
endmodule

// File: rtl/hp_dly_timer.sv
module hp_dly_timer #(
  parameter int DLY_NOEE = 610_000,
  parameter int DLY_EE   = 1_870_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eeprom_i,
  output logic expired_o
);
  localparam int DLY_MAX = (DLY_EE > DLY_NOEE) ? DLY_EE : DLY_NOEE;
  localparam int CW      = $clog2(DLY_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit     = eeprom_i ? CW'(DLY_EE) : CW'(DLY_NOEE);
  assign expired_o = (cnt_q >= limit);

  // counts from the first edge after reset exit, then saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DLY_MAX)); // R7
  AST_EXPIRED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && $stable(eeprom_i)) |=> expired_o); // R9
endmodule

// File: rtl/hp_slot_seq.sv
module hp_slot_seq
  import hp_seq_pkg::*;
#(
  parameter int DLY_NOEE    = 610_000,
  parameter int DLY_EE      = 1_870_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mrl_ni,
  input  logic eeprom_present_i,
  input  logic cfg_ctrl_present_i,
  input  logic cfg_mrl_present_i,
  input  logic cfg_pwr_ctrl_i,
  output logic pwr_en_no,
  output logic pwr_led_no,
  output logic attn_led_no,
  output logic pwr_ctrl_o
);
  localparam int DLY_MAX = (DLY_EE > DLY_NOEE) ? DLY_EE : DLY_NOEE;
  localparam int CW      = $clog2(DLY_MAX + 1);

  logic      mrl_sync_n;
  logic      sampled;
  logic      expired;
  logic      pwr_on;
  slot_cfg_t cfg_in;
  slot_cfg_t cfg_q;

  assign cfg_in = '{ctrl_present: cfg_ctrl_present_i, mrl_present: cfg_mrl_present_i,
                    pwr_ctrl: cfg_pwr_ctrl_i, eeprom: eeprom_present_i};

  hp_mrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .mrl_ni      (mrl_ni),
    .mrl_sync_no (mrl_sync_n)
  );

  hp_pwr_decide u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mrl_sync_ni (mrl_sync_n),
    .cfg_i       (cfg_in),
    .sampled_o   (sampled),
    .cfg_o       (cfg_q)
  );

  hp_dly_timer #(.DLY_NOEE(DLY_NOEE), .DLY_EE(DLY_EE)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eeprom_i  (cfg_q.eeprom),
    .expired_o (expired)
  );

  assign pwr_on      = sampled & expired & cfg_q.ctrl_present & ~cfg_q.pwr_ctrl;
  assign pwr_en_no   = ~pwr_on;
  assign pwr_led_no  = ~pwr_on;
  assign attn_led_no = 1'b1;
  assign pwr_ctrl_o  = cfg_q.pwr_ctrl;

  // checker-side cycle count since reset exit, independent of the timer
  logic [CW-1:0] chk_cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       chk_cyc_q <= '0;
    else if (chk_cyc_q < CW'(DLY_MAX)) chk_cyc_q <= chk_cyc_q + 1'b1;
  end

  AST_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_no) |-> (chk_cyc_q == (cfg_q.eeprom ? CW'(DLY_EE) : CW'(DLY_NOEE)))); // R7 R8
  AST_OFF_WHEN_CTRL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_ctrl_o |-> pwr_en_no); // R4
  AST_NEED_CONTROLLER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sampled && !cfg_q.ctrl_present) |-> pwr_en_no); // R6
  AST_STAY_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_no |=> !pwr_en_no); // R9
endmodule

// File: tb/hp_slot_seq_bench.sv
module hp_slot_seq_bench;
  localparam int D_NOEE = 12;
  localparam int D_EE   = 30;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mrl_ni = 1'b1;
  logic eeprom_present_i = 1'b0;
  logic cfg_ctrl_present_i = 1'b1;
  logic cfg_mrl_present_i = 1'b1;
  logic cfg_pwr_ctrl_i = 1'b1;
  logic pwr_en_no, pwr_led_no, attn_led_no, pwr_ctrl_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  hp_slot_seq #(.DLY_NOEE(D_NOEE), .DLY_EE(D_EE)) u_hp_slot_seq (
    .clk_i, .rst_ni, .mrl_ni, .eeprom_present_i, .cfg_ctrl_present_i,
    .cfg_mrl_present_i, .cfg_pwr_ctrl_i, .pwr_en_no, .pwr_led_no,
    .attn_led_no, .pwr_ctrl_o
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", tag, k, act, exp);
    end
  endtask

  task automatic chk_reset_state();
    chk("R1 pwr_en", pwr_en_no, 1'b1, 0);
    chk("R1 pwr_led", pwr_led_no, 1'b1, 0);
    chk("R1 attn", attn_led_no, 1'b1, 0);
    chk("R1 pwr_ctrl", pwr_ctrl_o, 1'b1, 0);
  endtask

  // v bits: 0 ctrl_present, 1 mrl_present, 2 cfg pwr_ctrl, 3 mrl_n, 4 eeprom
  task automatic run_case(input int v, input int extra);
    logic cp, mp, pc, mn, ee, exp_pc, en;
    int d;
    string tpc, ten;
    cp = v[0]; mp = v[1]; pc = v[2]; mn = v[3]; ee = v[4];
    @(negedge clk_i);
    rst_ni = 1'b0;
    cfg_ctrl_present_i = cp; cfg_mrl_present_i = mp; cfg_pwr_ctrl_i = pc;
    mrl_ni = mn; eeprom_present_i = ee;
    #1 chk_reset_state();
    repeat (3) @(negedge clk_i);
    chk_reset_state();
    rst_ni = 1'b1;
    exp_pc = pc & ~(mp & ~mn);
    en = cp & ~exp_pc;
    d = ee ? D_EE : D_NOEE;
    tpc = !mp ? "R5" : (mn ? "R4" : "R3");
    ten = !en ? "R6" : (ee ? "R8" : "R7");
    for (int k = 1; k <= d + extra; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk(tpc, pwr_ctrl_o, exp_pc, k);
      chk(ten, pwr_en_no, !(en && k >= d), k);
      chk(ten, pwr_led_no, !(en && k >= d), k);
      chk("R2", attn_led_no, 1'b1, k);
      if (k == 3) begin // R9: late changes ignored
        mrl_ni = ~mn; cfg_ctrl_present_i = ~cp; cfg_mrl_present_i = ~mp;
        cfg_pwr_ctrl_i = ~pc; eeprom_present_i = ~ee;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk_reset_state();
    for (int v = 0; v < 32; v++) run_case(v, 4);
    // R10: powered slot, reset mid-run, full delay restarts
    run_case(5'b00001, 2);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10 pwr_en", pwr_en_no, 1'b1, 0);
    chk("R10 pwr_ctrl", pwr_ctrl_o, 1'b1, 0);
    cfg_ctrl_present_i = 1'b1; cfg_mrl_present_i = 1'b0; cfg_pwr_ctrl_i = 1'b0;
    eeprom_present_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 1; k <= D_NOEE; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      chk("R10", pwr_en_no, !(k >= D_NOEE), k);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule